// File: doc/BRIEF.md
# Externally Clocked Serial Read Port with Data-Ready Flag

This block is the device-side read path of a converter's serial interface when the host owns the serial clock. The host pulls the active-low frame strobe and toggles the serial clock. The block then shifts out one of three 24-bit sources, most significant bit first. The select input and the calibration pick input together choose the source: the latest conversion word, the calibration register or the control register. The serial clock and the frame strobe are brought into the system clock domain through synchronizers. Output data changes only on synchronized falling edges of the serial clock.

An active-low data-ready flag gates reads of the conversion word. The flag drops when the conversion core strobes a new word in, and it rises once the last bit of that word has been shifted out. A conversion-word read may be spread over several frames. Between frames the block holds the snapshot and the bit position, and any word that arrives while such a read is open is lost to the reader.

Control flow is a four-state machine. IDLE means no frame and no open read. SHIFT means a frame is active and bits are being sent. PAUSE means no frame, with a conversion-word read open. SKIP means a frame is active but nothing is sent.

The transitions are as follows:
- **start** (IDLE to SHIFT): frame falls with a source that may be read.
- **refuse** (IDLE to SKIP): frame falls on the conversion word while data-ready is high.
- **finish** (SHIFT to SKIP): the last bit is clocked out.
- **suspend** (SHIFT to PAUSE): frame rises during a conversion-word read.
- **abandon** (SHIFT to IDLE): frame rises during a control or calibration read.
- **resume** (PAUSE to SHIFT): frame falls with the conversion word selected.
- **bypass** (PAUSE to SKIP): frame falls with another source selected.
- **release** (SKIP to PAUSE or IDLE): frame rises; the target is PAUSE if a read is still open, otherwise IDLE.

Top module: `serial_read_port`

## Requirements
- R1: With `sel_in` low, a frame shifts out `ctrl_word`. With `sel_in` high and `cal_pick` high, it shifts out `cal_word`. With `sel_in` high and `cal_pick` low, it shifts out the conversion word. Bits are sent from bit 23 downward, and control and calibration reads are 24 bits long.
- R2: `drdy_n` resets high. It goes low once `new_word_stb` loads a word while no conversion-word read is open.
- R3: `drdy_n` returns high at the final serial-clock falling edge of a conversion-word read. The read is 24 bits (bits 23..0) with `word16` low, or 16 bits (bits 23..8) with `word16` high, and `word16` is sampled at the read's first frame.
- R4: While no read takes place, further words keep replacing the conversion word, `drdy_n` stays low, and a later read returns the newest word.
- R5: A word strobed in while a conversion-word read is open is not flagged. After that read completes, `drdy_n` is high and stays high.
- R6: A frame selecting the conversion word while `drdy_n` is high and no read is open transfers nothing: `sdo_en` stays low and `drdy_n` stays high.
- R7: Control and calibration reads leave `drdy_n` unchanged. Such a read cut short by the frame rising is abandoned, and the next frame starts again from bit 23.
- R8: A conversion-word read may span several frames, and each frame continues at the next unsent bit. During an open read, frames selecting another source send nothing.
- R9: The first bit is on `sdo` once the frame start has been synchronized. `sdo` changes only after synchronized serial-clock falling edges.
- R10: `sdo_en` is low whenever the frame strobe is high, and it is low in a frame after the word has completed.
- R11: The conversion word is captured when a read starts. Words arriving later do not alter the bits sent by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the host (idles high) |
| frame_n | input | 1 | Active-low receive frame strobe |
| sel_in | input | 1 | High: conversion/calibration; low: control |
| cal_pick | input | 1 | With `sel_in` high, picks calibration over conversion word |
| word16 | input | 1 | Conversion word length: 1 = 16 bits, 0 = 24 bits |
| new_word_stb | input | 1 | One-cycle strobe of a new conversion word |
| new_word | input | 24 | New conversion word |
| cal_word | input | 24 | Calibration register contents |
| ctrl_word | input | 24 | Control register contents |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the pad (low = high impedance) |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The bench builds the block with its default 24-bit word, 16-bit short length and two synchronizer stages. At these values both conversion word lengths, splits at arbitrary bit positions and the full control and calibration length are reachable in a few hundred serial clocks. The serial half-period of six system clocks leaves the three-cycle synchronizer-plus-state latency settled before each sample. Random sequences mix word arrivals, split reads, refused frames and reads of other sources against a bench model of the flag, the snapshot and the bit position.

// File: rtl/srd_pkg.sv
package srd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAUSE = 2'd2,
        ST_SKIP  = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        SRC_CTRL = 2'd0,
        SRC_CAL  = 2'd1,
        SRC_OUT  = 2'd2
    } rd_src_e;
endpackage

// File: rtl/srd_sync.sv
module srd_sync #(
    parameter int                N_SIG   = 2,
    parameter int                STAGES  = 2,
    parameter logic [N_SIG-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] level,
    output logic [N_SIG-1:0] fall,
    output logic [N_SIG-1:0] rise
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        logic [STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {(STAGES+1){RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-1:0], din[g]};
        end
        assign level[g] = pipe[STAGES-1];
        assign fall[g]  = pipe[STAGES] & ~pipe[STAGES-1];
        assign rise[g]  = ~pipe[STAGES] & pipe[STAGES-1];
    end
endmodule

// File: rtl/srd_ready.sv
module srd_ready #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_stb,
    input  logic [DATA_W-1:0] new_word,
    input  logic              read_busy,
    input  logic              read_done,
    output logic [DATA_W-1:0] out_word,
    output logic              drdy_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            drdy_n   <= 1'b1;
        end else begin
            if (new_stb) out_word <= new_word;
            if (read_done)                  drdy_n <= 1'b1;
            else if (new_stb && !read_busy) drdy_n <= 1'b0;
        end
    end

    assert_flag_on_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (new_stb && !read_busy && !read_done) |=> !drdy_n);
    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> drdy_n);
    assert_rise_only_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_n) |-> $past(read_done));
endmodule

// File: rtl/srd_read_fsm.sv
module srd_read_fsm
    import srd_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_hi,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              sclk_fall,
    input  logic              sel_hi,
    input  logic              cal_pick,
    input  logic              word16,
    input  logic              drdy_n,
    input  logic [DATA_W-1:0] out_word,
    input  logic [DATA_W-1:0] cal_word,
    input  logic [DATA_W-1:0] ctrl_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              read_busy,
    output logic              read_done
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

    rd_state_e         state_q, state_nx;
    rd_src_e           src_q, src_nx;
    logic [DATA_W-1:0] shreg_q, load_word;
    logic [CNT_W-1:0]  cnt_q, load_len;
    logic              load, shift, fin, clear, pending;

    assign pending = (src_q == SRC_OUT) && (cnt_q != '0);

    always_comb begin
        state_nx  = state_q;
        src_nx    = src_q;
        load      = 1'b0;
        load_word = '0;
        load_len  = LEN_FULL;
        shift     = 1'b0;
        fin       = 1'b0;
        clear     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (frame_start) begin
                if (!sel_hi) begin
                    state_nx = ST_SHIFT; src_nx = SRC_CTRL; load = 1'b1; load_word = ctrl_word;
                end else if (cal_pick) begin
                    state_nx = ST_SHIFT; src_nx = SRC_CAL; load = 1'b1; load_word = cal_word;
                end else if (!drdy_n) begin
                    state_nx = ST_SHIFT; src_nx = SRC_OUT; load = 1'b1; load_word = out_word;
                    load_len = word16 ? LEN_SHORT : LEN_FULL;
                end else begin
                    state_nx = ST_SKIP;
                end
            end
            ST_SHIFT: begin
                if (frame_end) begin
                    if (src_q == SRC_OUT) state_nx = ST_PAUSE;
                    else begin state_nx = ST_IDLE; clear = 1'b1; end
                end else if (sclk_fall) begin
                    shift = 1'b1;
                    if (cnt_q == CNT_W'(1)) begin fin = 1'b1; state_nx = ST_SKIP; end
                end
            end
            ST_PAUSE: if (frame_start) state_nx = (sel_hi && !cal_pick) ? ST_SHIFT : ST_SKIP;
            ST_SKIP:  if (frame_end)   state_nx = pending ? ST_PAUSE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_CTRL;
        end else begin
            state_q <= state_nx;
            src_q   <= src_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= load_word;
            cnt_q   <= load_len;
        end else if (shift) begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            cnt_q   <= cnt_q - CNT_W'(1);
        end else if (clear) begin
            cnt_q   <= '0;
        end
    end

    always_comb begin
        sdo       = shreg_q[DATA_W-1];
        sdo_en    = (state_q == ST_SHIFT);
        read_busy = pending && (state_q != ST_IDLE);
        read_done = fin && (src_q == SRC_OUT);
    end

    assert_hiz_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hi && $past(frame_hi)) |-> !sdo_en);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LEN_FULL);
    assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_fall && !frame_end && cnt_q > CNT_W'(1))
            |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    assert_hold_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && $past(state_q == ST_PAUSE)) |-> ($stable(shreg_q) && $stable(cnt_q)));
    assert_sdo_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q == ST_SHIFT) && !$past(sclk_fall)) |-> $stable(sdo));
endmodule

// File: rtl/serial_read_port.sv
module serial_read_port #(
    parameter int DATA_W      = 24,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              frame_n,
    input  logic              sel_in,
    input  logic              cal_pick,
    input  logic              word16,
    input  logic              new_word_stb,
    input  logic [DATA_W-1:0] new_word,
    input  logic [DATA_W-1:0] cal_word,
    input  logic [DATA_W-1:0] ctrl_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              drdy_n
);
    logic [1:0]        lvl, fall, rise;
    logic [DATA_W-1:0] out_word;
    logic              read_busy, read_done;

    srd_sync #(.N_SIG(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({frame_n, sclk_in}),
        .level(lvl), .fall(fall), .rise(rise)
    );

    srd_ready #(.DATA_W(DATA_W)) u_ready (
        .clk(clk), .rst_n(rst_n), .new_stb(new_word_stb), .new_word(new_word),
        .read_busy(read_busy), .read_done(read_done),
        .out_word(out_word), .drdy_n(drdy_n)
    );

    srd_read_fsm #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_hi(lvl[1]), .frame_start(fall[1]), .frame_end(rise[1]),
        .sclk_fall(fall[0]),
        .sel_hi(sel_in), .cal_pick(cal_pick), .word16(word16), .drdy_n(drdy_n),
        .out_word(out_word), .cal_word(cal_word), .ctrl_word(ctrl_word),
        .sdo(sdo), .sdo_en(sdo_en), .read_busy(read_busy), .read_done(read_done)
    );
endmodule

// File: tb/serial_read_port_tb.sv
module serial_read_port_tb_top;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b1, frame_n = 1'b1, sel_in = 1'b1, cal_pick = 1'b0, word16 = 1'b0;
    logic        new_word_stb = 1'b0;
    logic [23:0] new_word = '0, cal_word = 24'hC0A1B2, ctrl_word = 24'h5E3D17;
    logic        sdo, sdo_en, drdy_n;

    int n_chk = 0, n_bad = 0;

    // bench model
    logic [23:0] m_out = '0, m_snap = '0;
    logic        m_drdy_n = 1'b1;
    int          m_len = 24, m_pend = 0;

    always #5 clk = ~clk;

    serial_read_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .frame_n(frame_n),
        .sel_in(sel_in), .cal_pick(cal_pick), .word16(word16),
        .new_word_stb(new_word_stb), .new_word(new_word),
        .cal_word(cal_word), .ctrl_word(ctrl_word),
        .sdo(sdo), .sdo_en(sdo_en), .drdy_n(drdy_n)
    );

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] seg(input logic [23:0] w, input int start, input int k);
        logic [23:0] v;
        v = w << start;
        return v >> (24 - k);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [23:0] w);
        @(negedge clk);
        new_word_stb = 1'b1; new_word = w;
        @(negedge clk);
        new_word_stb = 1'b0;
        wait_clk(2);
        m_out = w;
        if (m_pend == 0) m_drdy_n = 1'b0;
    endtask

    // Runs one frame of nbits serial clocks; collects sdo; reports enable observations.
    task automatic frame(input logic s, input logic c, input int nbits,
                         output logic [23:0] got, output bit en_all, output bit en_any,
                         output logic en_after);
        got = '0; en_all = 1'b1; en_any = 1'b0;
        sel_in = s; cal_pick = c;
        wait_clk(1);
        frame_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            got = {got[22:0], sdo};
            en_all = en_all & sdo_en;
            en_any = en_any | sdo_en;
            sclk_in = 1'b0; wait_clk(HALF);
            sclk_in = 1'b1; wait_clk(HALF);
        end
        en_after = sdo_en;
        frame_n = 1'b1;
        wait_clk(HALF);
        check(!sdo_en, "R10 enable low with frame high", {23'd0, sdo_en}, 24'd0);
    endtask

    // Conversion-word read segment, checked against the model.
    task automatic out_read(input int nbits, input string tag);
        logic [23:0] got; bit ea, ey; logic aft; int k;
        if (m_pend == 0 && m_drdy_n) begin
            frame(1'b1, 1'b0, nbits, got, ea, ey, aft);
            check(!ey, {tag, " R6 no transfer"}, {23'd0, ey}, 24'd0);
            check(drdy_n == 1'b1, {tag, " R6 flag stays high"}, {23'd0, drdy_n}, 24'd1);
            return;
        end
        if (m_pend == 0) begin
            m_snap = m_out; m_len = word16 ? 16 : 24; m_pend = m_len;
        end
        k = (nbits > m_pend) ? m_pend : nbits;
        frame(1'b1, 1'b0, k, got, ea, ey, aft);
        check(ea, {tag, " R8 enable during read"}, {23'd0, ea}, 24'd1);
        check(got[23:0] == seg(m_snap, m_len - m_pend, k), {tag, " R1 R11 bits"},
              got, seg(m_snap, m_len - m_pend, k));
        m_pend -= k;
        if (m_pend == 0) begin
            m_drdy_n = 1'b1;
            check(aft == 1'b0, {tag, " R10 enable low after word"}, {23'd0, aft}, 24'd0);
        end
        check(drdy_n == m_drdy_n, {tag, " R3 R5 flag after read"}, {23'd0, drdy_n}, {23'd0, m_drdy_n});
    endtask

    task automatic reg_read(input logic c, input int nbits, input string tag);
        logic [23:0] got, w; bit ea, ey; logic aft;
        w = c ? cal_word : ctrl_word;
        frame(c, c, nbits, got, ea, ey, aft);
        if (m_pend != 0) begin
            check(!ey, {tag, " R8 other source skipped"}, {23'd0, ey}, 24'd0);
        end else begin
            check(ea && got == seg(w, 0, nbits), {tag, " R1 register bits"}, got, seg(w, 0, nbits));
        end
        check(drdy_n == m_drdy_n, {tag, " R7 flag unchanged"}, {23'd0, drdy_n}, {23'd0, m_drdy_n});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0107));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check(drdy_n == 1'b1 && sdo_en == 1'b0, "R2 reset state", {22'd0, drdy_n, sdo_en}, 24'd2);

        // R6: read with no word ready
        out_read(24, "refused");

        // R2: new word lowers flag
        push(24'hA5C3F0);
        check(drdy_n == 1'b0, "R2 flag low after word", {23'd0, drdy_n}, 24'd0);

        // R4: newer word replaces unread one
        push(24'h123456);
        check(drdy_n == 1'b0, "R4 flag still low", {23'd0, drdy_n}, 24'd0);
        out_read(24, "R4 newest");

        // R7: control and calibration reads, flag low and high
        push(24'h0F0F0F);
        reg_read(1'b0, 24, "R7 ctrl");
        reg_read(1'b1, 24, "R7 cal");
        // R7: abandoned control read restarts from top
        reg_read(1'b0, 7, "R7 short ctrl");
        reg_read(1'b0, 24, "R7 ctrl restart");

        // R8 + R5 + R11: split read with a new word arriving mid read
        out_read(10, "R8 part1");
        reg_read(1'b0, 24, "R8 ctrl mid");
        push(24'hDEAD01);
        check(drdy_n == 1'b0, "R5 flag not re-signalled", {23'd0, drdy_n}, 24'd0);
        out_read(14, "R8 part2");
        check(drdy_n == 1'b1, "R5 word lost", {23'd0, drdy_n}, 24'd1);
        out_read(24, "R5 refused after loss");

        // R3: 16-bit word length
        word16 = 1'b1;
        push(24'hBEEF77);
        out_read(5, "R3 short a");
        out_read(11, "R3 short b");
        word16 = 1'b0;

        // random mix
        for (int it = 0; it < 60; it++) begin
            int act;
            act = $urandom_range(0, 5);
            if (m_pend == 0 && $urandom_range(0, 3) == 0) word16 = $urandom_range(0, 1);
            case (act)
                0, 1: push($urandom);
                2, 3: out_read($urandom_range(1, 24), "rand out");
                4:    reg_read(1'b0, 24, "rand ctrl");
                default: reg_read(1'b1, 24, "rand cal");
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule